// File: doc/BRIEF.md
# Filtered Latched Fault Supervisor

This block sits between the analog fault comparators of a multi-channel half-bridge driver and its output stages. Each raw comparator flag (overcurrent and open-load per channel; temperature warning; thermal shutdown; undervoltage and overvoltage on the main, bank A, bank B and boost supplies) must hold for a minimum number of clock cycles before it counts. A qualified event sets a sticky status bit, and the block derives two kinds of permission from those bits: one per output channel and one for the boost converter.

Each fault has its own policy. Some faults are only reported. One fault stops its own channel. Some stop every channel. Some stop only the converter. Software removes a status bit with a masked clear strobe, and a clear has no effect while the qualified condition is still present. A recovery option lets the boost-supply overvoltage bit release by itself once the raw flag drops.

Top module: `fault_supervisor`

## Requirements
- R1: A fast-filtered flag (overcurrent, temperature warning, thermal shutdown and all supply flags) sets its status bit on the FAST_CYC-th consecutive rising clock edge that samples it high. A flag that is high for fewer edges leaves no trace, because the filter count restarts whenever the flag is sampled low.
- R2: Open-load on a channel counts only while `ch_on` for that channel is high. Its status bit sets on the SLOW_CYC-th consecutive edge with both the flag and `ch_on` high.
- R3: Status bits are sticky. A bit clears on an edge where `clr_req` is high and its mask bit is set. A clear issued while the qualified condition is still present has no effect.
- R4: A set `oc_stat[i]` forces `ch_en[i]` low, and only for channel i.
- R5: Open-load and temperature warning status (sys bit 0) change neither `ch_en` nor `conv_en`.
- R6: Thermal shutdown status (sys bit 1) forces every `ch_en` low. The channels come back only after the raw flag has dropped and the bit has been cleared.
- R7: Main-supply undervoltage status (sys bit 2) forces every `ch_en` low and `conv_en` low.
- R8: Main-supply overvoltage status (sys bit 3) forces every `ch_en` low unless `ovs_keep` is high. It never affects `conv_en`.
- R9: Bank A undervoltage (sys bit 4) and bank B undervoltage (sys bit 5) each force every `ch_en` low.
- R10: Boost-supply undervoltage (sys bit 6) is counted only while `conv_req` is high. Its status forces `conv_en` low.
- R11: Boost-supply overvoltage status (sys bit 7) forces `conv_en` low. With `v2_recover` high, the bit clears on the first edge that samples the raw flag low, and the converter is permitted again.
- R12: After reset every status bit is 0. `ch_en` then equals `ch_on` and `conv_en` equals `conv_req`. The same sys bit positions 0 to 7 are used in `sys_raw`, `clr_sys` and `sys_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_on | input | NCH | Channels commanded on |
| conv_req | input | 1 | Boost converter commanded on |
| ovs_keep | input | 1 | Keep outputs on during main-supply overvoltage |
| v2_recover | input | 1 | Auto-release of boost-supply overvoltage |
| oc_raw | input | NCH | Raw overcurrent flags |
| ol_raw | input | NCH | Raw open-load flags |
| sys_raw | input | 8 | Raw temperature and supply flags |
| clr_req | input | 1 | Clear strobe |
| clr_oc | input | NCH | Overcurrent clear mask |
| clr_ol | input | NCH | Open-load clear mask |
| clr_sys | input | 8 | Temperature and supply clear mask |
| oc_stat | output | NCH | Latched overcurrent status |
| ol_stat | output | NCH | Latched open-load status |
| sys_stat | output | 8 | Latched temperature and supply status |
| ch_en | output | NCH | Per-channel drive permission |
| conv_en | output | 1 | Converter permission |

## Verification
Some rules are checked by the assertions on every cycle. These are: bit stickiness and the rule that a qualified event beats a clear; a filter output rising only after the flag was already present; thermal shutdown and overcurrent forcing their channels off; gating of open-load by `ch_on` and of boost undervoltage by `conv_req`; and the one-edge auto-release. Other behaviour needs the bench's scenarios. These cover the exact edge on which each filter qualifies, one cycle short of the threshold versus exactly at it, the overvoltage keep option, faults that stay informational, and the order of flag drop and clear that brings the outputs back.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    localparam int unsigned NSYS = 8;

    // bit positions inside the temperature/supply vector
    typedef enum int unsigned {
        SB_TW   = 0,
        SB_TSD  = 1,
        SB_VSUV = 2,
        SB_VSOV = 3,
        SB_VAUV = 4,
        SB_VBUV = 5,
        SB_V2UV = 6,
        SB_V2OV = 7
    } sys_bit_e;

    // same layout as a packed struct, MSB first
    typedef struct packed {
        logic v2ov;
        logic v2uv;
        logic vbuv;
        logic vauv;
        logic vsov;
        logic vsuv;
        logic tsd;
        logic tw;
    } sys_flags_t;

    typedef enum logic {FLT_FAST, FLT_SLOW} flt_kind_e;

    function automatic int unsigned filt_len(flt_kind_e k, int unsigned fast_c,
                                             int unsigned slow_c);
        return (k == FLT_SLOW) ? slow_c : fast_c;
    endfunction

    // faults that stop every output channel
    function automatic logic bank_kill(sys_flags_t s, logic ovs_keep);
        return s.tsd | s.vsuv | (s.vsov & ~ovs_keep) | s.vauv | s.vbuv;
    endfunction

    // faults that stop the boost converter
    function automatic logic conv_kill(sys_flags_t s);
        return s.vsuv | s.v2uv | s.v2ov;
    endfunction

endpackage

// File: rtl/fsup_filter.sv
module fsup_filter #(
    parameter int unsigned THR = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic hit
);
    localparam int unsigned CW = (THR > 1) ? $clog2(THR) : 1;
    localparam logic [CW-1:0] TOP = CW'(THR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (!raw)      cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    // qualified once the flag has been present THR edges in a row
    assign hit = raw && (cnt == TOP);

    generate
        if (THR > 1) begin : g_chk
            // R1: the qualified output never rises without prior history
            a_r1_hit_needs_history: assert property (@(posedge clk) disable iff (rst)
                $rose(hit) |-> $past(raw));
            // R1: a low sample restarts the count
            a_r1_drop_restarts: assert property (@(posedge clk) disable iff (rst)
                !raw |=> !hit);
        end
    endgenerate

endmodule

// File: rtl/fsup_sticky.sv
module fsup_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic auto_clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~clr & ~auto_clr);
    end

    // R3: a set bit stays set without a release
    a_r3_holds: assert property (@(posedge clk) disable iff (rst)
        (q && !clr && !auto_clr) |=> q);
    // R3: a present condition wins over a clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
    // R3: no bit appears without a qualified event
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!q && !set) |=> !q);

endmodule

// File: rtl/fsup_policy.sv
module fsup_policy
    import fsup_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  ch_on,
    input  logic [NCH-1:0]  oc_q,
    input  logic [NSYS-1:0] sys_q,
    input  logic            ovs_keep,
    input  logic            conv_req,
    output logic [NCH-1:0]  ch_en,
    output logic            conv_en
);
    sys_flags_t s;
    logic       bank_off;

    assign s        = sys_flags_t'(sys_q);
    assign bank_off = bank_kill(s, ovs_keep);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign ch_en[i] = ch_on[i] & ~oc_q[i] & ~bank_off;
            // R4: a latched overcurrent keeps its channel off
            a_r4_oc_off: assert property (@(posedge clk) disable iff (rst)
                oc_q[i] |-> !ch_en[i]);
        end
    endgenerate

    assign conv_en = conv_req & ~conv_kill(s);

    // R6: thermal shutdown stops every channel
    a_r6_tsd_all_off: assert property (@(posedge clk) disable iff (rst)
        s.tsd |-> (ch_en == '0));
    // R7: main undervoltage stops the converter
    a_r7_vsuv_conv_off: assert property (@(posedge clk) disable iff (rst)
        s.vsuv |-> !conv_en);

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int unsigned NCH      = 8,
    parameter int unsigned FAST_CYC = 320,
    parameter int unsigned SLOW_CYC = 20000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  ch_on,
    input  logic            conv_req,
    input  logic            ovs_keep,
    input  logic            v2_recover,
    input  logic [NCH-1:0]  oc_raw,
    input  logic [NCH-1:0]  ol_raw,
    input  logic [NSYS-1:0] sys_raw,
    input  logic            clr_req,
    input  logic [NCH-1:0]  clr_oc,
    input  logic [NCH-1:0]  clr_ol,
    input  logic [NSYS-1:0] clr_sys,
    output logic [NCH-1:0]  oc_stat,
    output logic [NCH-1:0]  ol_stat,
    output logic [NSYS-1:0] sys_stat,
    output logic [NCH-1:0]  ch_en,
    output logic            conv_en
);
    localparam int unsigned OC_LEN  = filt_len(FLT_FAST, FAST_CYC, SLOW_CYC);
    localparam int unsigned OL_LEN  = filt_len(FLT_SLOW, FAST_CYC, SLOW_CYC);
    localparam int unsigned SYS_LEN = filt_len(FLT_FAST, FAST_CYC, SLOW_CYC);

    logic [NCH-1:0]  oc_hit, ol_hit, ol_gated;
    logic [NSYS-1:0] sys_gated, sys_hit, sys_auto;

    // open-load is only meaningful on a driven channel
    assign ol_gated = ol_raw & ch_on;

    always_comb begin
        sys_gated          = sys_raw;
        sys_gated[SB_V2UV] = sys_raw[SB_V2UV] & conv_req;
        sys_auto           = '0;
        sys_auto[SB_V2OV]  = v2_recover & ~sys_raw[SB_V2OV];
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            fsup_filter #(.THR(OC_LEN)) u_oc_flt (
                .clk(clk), .rst(rst), .raw(oc_raw[i]), .hit(oc_hit[i]));
            fsup_sticky u_oc_bit (
                .clk(clk), .rst(rst), .set(oc_hit[i]),
                .clr(clr_req & clr_oc[i]), .auto_clr(1'b0), .q(oc_stat[i]));

            fsup_filter #(.THR(OL_LEN)) u_ol_flt (
                .clk(clk), .rst(rst), .raw(ol_gated[i]), .hit(ol_hit[i]));
            fsup_sticky u_ol_bit (
                .clk(clk), .rst(rst), .set(ol_hit[i]),
                .clr(clr_req & clr_ol[i]), .auto_clr(1'b0), .q(ol_stat[i]));

            // R2: an undriven channel never gains an open-load bit
            a_r2_ol_gated: assert property (@(posedge clk) disable iff (rst)
                (!ch_on[i] && !ol_stat[i]) |=> !ol_stat[i]);
        end

        for (genvar b = 0; b < NSYS; b++) begin : g_sys
            fsup_filter #(.THR(SYS_LEN)) u_flt (
                .clk(clk), .rst(rst), .raw(sys_gated[b]), .hit(sys_hit[b]));
            fsup_sticky u_bit (
                .clk(clk), .rst(rst), .set(sys_hit[b]),
                .clr(clr_req & clr_sys[b]), .auto_clr(sys_auto[b]), .q(sys_stat[b]));
        end
    endgenerate

    fsup_policy #(.NCH(NCH)) u_policy (
        .clk(clk), .rst(rst), .ch_on(ch_on), .oc_q(oc_stat), .sys_q(sys_stat),
        .ovs_keep(ovs_keep), .conv_req(conv_req), .ch_en(ch_en), .conv_en(conv_en));

    // R10: boost undervoltage is not recorded while the converter is idle
    a_r10_v2uv_gated: assert property (@(posedge clk) disable iff (rst)
        (!conv_req && !sys_stat[SB_V2UV]) |=> !sys_stat[SB_V2UV]);
    // R11: auto-release takes a single edge once the flag is gone
    a_r11_auto_release: assert property (@(posedge clk) disable iff (rst)
        (v2_recover && !sys_raw[SB_V2OV]) |=> !sys_stat[SB_V2OV]);

endmodule

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
    localparam int NCH      = 4;
    localparam int FAST     = 4;
    localparam int SLOW     = 10;
    localparam time CLK_P   = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] ch_on = '1, oc_raw = '0, ol_raw = '0, clr_oc = '0, clr_ol = '0;
    logic conv_req = 1'b1, ovs_keep = 1'b0, v2_recover = 1'b0, clr_req = 1'b0;
    logic [7:0] sys_raw = '0, clr_sys = '0;
    logic [NCH-1:0] oc_stat, ol_stat, ch_en;
    logic [7:0] sys_stat;
    logic conv_en;

    always #(CLK_P/2) clk = ~clk;

    fault_supervisor #(.NCH(NCH), .FAST_CYC(FAST), .SLOW_CYC(SLOW)) i_fault_supervisor (
        .clk(clk), .rst(rst), .ch_on(ch_on), .conv_req(conv_req), .ovs_keep(ovs_keep),
        .v2_recover(v2_recover), .oc_raw(oc_raw), .ol_raw(ol_raw), .sys_raw(sys_raw),
        .clr_req(clr_req), .clr_oc(clr_oc), .clr_ol(clr_ol), .clr_sys(clr_sys),
        .oc_stat(oc_stat), .ol_stat(ol_stat), .sys_stat(sys_stat),
        .ch_en(ch_en), .conv_en(conv_en));

    typedef struct {
        string          tag;
        logic [NCH-1:0] oc, ol, chen;
        logic [7:0]     sys;
        logic           conv;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [NCH-1:0] e_oc = '0, e_ol = '0;
    logic [7:0] e_sys = '0;

    // driver side: push the expected state after the next edge, then advance
    task automatic chk(string tag);
        exp_t it;
        logic bank;
        bank = e_sys[1] | e_sys[2] | (e_sys[3] & ~ovs_keep) | e_sys[4] | e_sys[5];
        it.tag  = tag;
        it.oc   = e_oc;
        it.ol   = e_ol;
        it.sys  = e_sys;
        it.chen = ch_on & ~e_oc & {NCH{~bank}};
        it.conv = conv_req & ~(e_sys[2] | e_sys[6] | e_sys[7]);
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic raise_sys(int b, string tag);
        sys_raw[b] = 1'b1;
        tick(FAST - 1);
        e_sys[b] = 1'b1;
        chk(tag);
    endtask

    task automatic drop_clear_sys(int b, string tag);
        sys_raw[b] = 1'b0;
        clr_req = 1'b1;
        clr_sys = 8'(1 << b);
        e_sys[b] = 1'b0;
        chk(tag);
        clr_req = 1'b0;
        clr_sys = '0;
    endtask

    // monitor side: pop and compare a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() != 0) begin
                exp_t it;
                it = q.pop_front();
                n_chk++;
                if (oc_stat !== it.oc || ol_stat !== it.ol || sys_stat !== it.sys ||
                    ch_en !== it.chen || conv_en !== it.conv) begin
                    n_err++;
                    $display("FAIL %s: oc %b/%b ol %b/%b sys %b/%b ch_en %b/%b conv %b/%b",
                             it.tag, oc_stat, it.oc, ol_stat, it.ol, sys_stat, it.sys,
                             ch_en, it.chen, conv_en, it.conv);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        chk("R12 reset state");

        // R1: one edge short of the threshold leaves nothing
        oc_raw[0] = 1'b1;
        tick(FAST - 1);
        oc_raw[0] = 1'b0;
        chk("R1 short overcurrent pulse ignored");
        chk("R1 still clear after pulse");

        // R1 boundary then R4 single channel off
        oc_raw[0] = 1'b1;
        tick(FAST - 2);
        chk("R1 not set one edge early");
        e_oc[0] = 1'b1;
        chk("R4 overcurrent latches and stops channel 0 only");

        // R3: clear while present has no effect
        clr_req = 1'b1; clr_oc = 4'b0001;
        chk("R3 clear ignored while present");
        clr_req = 1'b0; clr_oc = '0;
        oc_raw[0] = 1'b0;
        chk("R3 bit sticky after flag drops");
        clr_req = 1'b1; clr_oc = 4'b0001;
        e_oc[0] = 1'b0;
        chk("R3 clear releases bit");
        clr_req = 1'b0; clr_oc = '0;

        // R2: open-load on an undriven channel is ignored
        ch_on[1] = 1'b0;
        ol_raw[1] = 1'b1;
        tick(SLOW + 2);
        chk("R2 open-load ignored on off channel");
        ch_on[1] = 1'b1;
        tick(SLOW - 2);
        chk("R2 open-load not set one edge early");
        e_ol[1] = 1'b1;
        chk("R2 open-load set; R5 no effect on enables");
        ol_raw[1] = 1'b0;
        clr_req = 1'b1; clr_ol = 4'b0010;
        e_ol[1] = 1'b0;
        chk("R2 open-load cleared");
        clr_req = 1'b0; clr_ol = '0;

        // R5: temperature warning only reports
        raise_sys(0, "R5 temperature warning leaves enables alone");
        drop_clear_sys(0, "R5 warning cleared");

        // R6: thermal shutdown
        raise_sys(1, "R6 thermal shutdown stops all channels");
        clr_req = 1'b1; clr_sys = 8'h02;
        chk("R6 clear ignored while hot");
        clr_req = 1'b0; clr_sys = '0;
        sys_raw[1] = 1'b0;
        chk("R6 still off after cooling without clear");
        clr_req = 1'b1; clr_sys = 8'h02;
        e_sys[1] = 1'b0;
        chk("R6 channels back after clear");
        clr_req = 1'b0; clr_sys = '0;

        // R7: main undervoltage
        raise_sys(2, "R7 main undervoltage stops channels and converter");
        drop_clear_sys(2, "R7 recovered after clear");

        // R8: main overvoltage and keep option
        raise_sys(3, "R8 main overvoltage stops channels, converter stays");
        ovs_keep = 1'b1;
        chk("R8 keep option leaves channels on");
        ovs_keep = 1'b0;
        drop_clear_sys(3, "R8 cleared");

        // R9: bank undervoltage
        raise_sys(4, "R9 bank A undervoltage stops all channels");
        drop_clear_sys(4, "R9 bank A cleared");
        raise_sys(5, "R9 bank B undervoltage stops all channels");
        drop_clear_sys(5, "R9 bank B cleared");

        // R10: boost undervoltage gating
        conv_req = 1'b0;
        sys_raw[6] = 1'b1;
        tick(FAST + 2);
        chk("R10 boost undervoltage ignored while converter idle");
        conv_req = 1'b1;
        tick(FAST - 1);
        e_sys[6] = 1'b1;
        chk("R10 boost undervoltage stops converter");
        drop_clear_sys(6, "R10 converter back after clear");

        // R11: boost overvoltage without and with auto-release
        raise_sys(7, "R11 boost overvoltage stops converter");
        sys_raw[7] = 1'b0;
        chk("R11 sticky without recovery option");
        clr_req = 1'b1; clr_sys = 8'h80;
        e_sys[7] = 1'b0;
        chk("R11 manual clear");
        clr_req = 1'b0; clr_sys = '0;
        v2_recover = 1'b1;
        raise_sys(7, "R11 set with recovery option");
        sys_raw[7] = 1'b0;
        e_sys[7] = 1'b0;
        chk("R11 auto-release on first low sample");
        v2_recover = 1'b0;

        tick(3);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule